// File: doc/BRIEF.md
# Fuse Key Register Readout Controller

This block fronts a one-time-programmable key store with a small memory-mapped register bus. Software fetches one 32-bit key word by writing a command word to the control register. The command names the word index, carries an access key byte and sets a start bit. When the access key matches, the block starts a fuse read that lasts a fixed number of cycles. The start bit reads back as a live busy flag and drops when the word has arrived. The fetched word then appears in the read-data register.

The block also exposes a direct-read shadow window of 64 words. After reset the window holds a fixed stale pattern, not the fuse contents. A word in the window becomes correct only after the same index has been fetched through the register path. Software that wants the fast window must first walk every index through the command register once. The fuse array itself is a behavioural ROM whose contents are computed from the index.

Top module: `fkr_ctrl`

## Requirements
- R1: After reset, the control register (byte offset 0x40) and the read-data register (byte offset 0x60) read 0, and every shadow word at 0x200 + 4*i (i = 0..63) reads 0xDEADBEEF.
- R2: A control write starts a fuse read only if bit 1 is 1 and bits 15:8 equal 0xAC. The word index is taken from bits 24:16.
- R3: After an accepted command, control bit 1 reads 1 for exactly READ_LAT cycles (default 16) and then reads 0.
- R4: When a read completes, the read-data register holds the fuse word of the requested index. The fuse word at index i is ((i+1) * 0x9E3779B1) mod 2^32. The read-data register changes at no other time.
- R5: A completed read of an index below 64 makes shadow word i read the fuse word. Indices 64 and above change no shadow word.
- R6: A control write with a wrong access byte, or with bit 1 clear, starts no read and changes no readable state.
- R7: A control write made while a read is in progress is ignored. The index in flight and its result are unchanged.
- R8: Writing 0 to the control register after a read completes leaves the read-data register and the control readback unchanged.
- R9: Reads from unmapped offsets return 0. Writes to the read-data register, to the shadow window and to unmapped offsets have no effect.
- R10: Control readback is {7'b0, index[8:0], access byte[7:0], 6'b0, busy, 1'b0}, using the index and byte of the last accepted command.
- R11: Every read request gets rsp_valid exactly one cycle later, with rsp_data holding the register value from the cycle of the request. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 12 | Byte address; bits 1:0 are ignored |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid, one cycle after a read request |
| rsp_data | output | 32 | Read response data |

## Verification
The assertions assume one bus request per cycle at most. They also assume the bus inputs are held stable around the clock edge. The stimulus keeps to this by driving every request at the falling edge for a single cycle.

The assertions on held state also assume that reset is not reasserted while a read is in flight. The stimulus asserts reset only once, at the start. Commands arriving during a read, bad access bytes and clear start bits are all driven on purpose. The bench's reference model then shows that each of them leaves the readable state alone.

// File: rtl/fkr_pkg.sv
package fkr_pkg;

    localparam int unsigned FKR_ADDR_W       = 12;
    localparam int unsigned FKR_DATA_W       = 32;
    localparam int unsigned FKR_IDX_W        = 9;
    localparam int unsigned FKR_SHADOW_WORDS = 64;
    localparam int unsigned FKR_READ_LAT     = 16;

    localparam logic [FKR_ADDR_W-1:0] FKR_CTRL_OFF    = 12'h040;
    localparam logic [FKR_ADDR_W-1:0] FKR_DATA_OFF    = 12'h060;
    localparam logic [FKR_ADDR_W-1:0] FKR_SHADOW_BASE = 12'h200;
    localparam logic [7:0]            FKR_KEY         = 8'hAC;
    localparam logic [FKR_DATA_W-1:0] FKR_STALE       = 32'hDEADBEEF;

    // Control word layout; the field positions are what software programs.
    typedef struct packed {
        logic [6:0]           pad_hi;
        logic [FKR_IDX_W-1:0] idx;
        logic [7:0]           key;
        logic [5:0]           pad_mid;
        logic                 start;
        logic                 pad_lo;
    } fkr_ctrl_t;

    typedef enum logic {
        FKR_IDLE  = 1'b0,
        FKR_FETCH = 1'b1
    } fkr_state_t;

    // Completion event handed from the sequencer to the shadow window.
    typedef struct packed {
        logic                  valid;
        logic [FKR_IDX_W-1:0]  idx;
        logic [FKR_DATA_W-1:0] word;
    } fkr_done_t;

    // Behavioural fuse content: a multiplicative hash of the index.
    function automatic logic [FKR_DATA_W-1:0] fkr_fuse_word(input logic [FKR_IDX_W-1:0] i);
        logic [FKR_DATA_W-1:0] n;
        n = FKR_DATA_W'(i) + FKR_DATA_W'(1);
        return n * 32'h9E3779B1;
    endfunction

endpackage

// File: rtl/fkr_fuse_rom.sv
module fkr_fuse_rom
    import fkr_pkg::*;
#(
    parameter int unsigned DATA_W = FKR_DATA_W
) (
    input  logic [FKR_IDX_W-1:0] idx,
    output logic [DATA_W-1:0]    word
);

    assign word = DATA_W'(fkr_fuse_word(idx));

endmodule

// File: rtl/fkr_seq.sv
module fkr_seq
    import fkr_pkg::*;
#(
    parameter int unsigned READ_LAT = FKR_READ_LAT,
    parameter logic [7:0]  KEY      = FKR_KEY
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_wr,
    input  fkr_ctrl_t             cmd_word,
    output logic                  busy,
    output logic [FKR_IDX_W-1:0]  idx_q,
    output logic [7:0]            key_q,
    output logic [FKR_DATA_W-1:0] data_q,
    output fkr_done_t             done
);

    localparam int unsigned CNT_W = $clog2(READ_LAT + 1);

    fkr_state_t            state;
    logic [CNT_W-1:0]      cnt;
    logic [FKR_DATA_W-1:0] rom_word;
    logic                  accept;
    logic                  bad_cmd;
    logic                  unused_pad;

    assign unused_pad = ^{cmd_word.pad_hi, cmd_word.pad_mid, cmd_word.pad_lo};

    fkr_fuse_rom #(.DATA_W(FKR_DATA_W)) rom_i (
        .idx  (idx_q),
        .word (rom_word)
    );

    assign busy    = (state == FKR_FETCH);
    assign bad_cmd = !cmd_word.start || (cmd_word.key != KEY);
    assign accept  = cmd_wr && !busy && !bad_cmd;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= FKR_IDLE;
            cnt    <= '0;
            idx_q  <= '0;
            key_q  <= '0;
            data_q <= '0;
        end else begin
            case (state)
                FKR_IDLE: begin
                    if (accept) begin
                        state <= FKR_FETCH;
                        cnt   <= CNT_W'(READ_LAT - 1);
                        idx_q <= cmd_word.idx;
                        key_q <= cmd_word.key;
                    end
                end
                FKR_FETCH: begin
                    if (cnt == '0) begin
                        state  <= FKR_IDLE;
                        data_q <= rom_word;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                default: state <= FKR_IDLE;
            endcase
        end
    end

    always_comb begin
        done.valid = busy && (cnt == '0);
        done.idx   = idx_q;
        done.word  = rom_word;
    end

    // R7
    idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(idx_q) && $stable(key_q)));

    // R6
    reject_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !busy && bad_cmd) |=> (!busy && $stable(idx_q) && $stable(key_q) && $stable(data_q)));

    // R4
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done.valid |=> $stable(data_q));

    // R3
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done.valid |=> !busy);

endmodule

// File: rtl/fkr_shadow.sv
module fkr_shadow
    import fkr_pkg::*;
#(
    parameter int unsigned          WORDS  = FKR_SHADOW_WORDS,
    parameter int unsigned          DATA_W = FKR_DATA_W,
    parameter logic [DATA_W-1:0]    STALE  = FKR_STALE,
    localparam int unsigned         IDX_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [WORDS-1:0][DATA_W-1:0] mem_q;

    for (genvar g = 0; g < WORDS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                mem_q[g] <= STALE;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                mem_q[g] <= wr_data;
            end
        end
    end

    assign rd_data = mem_q[rd_idx];

    // R9
    shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mem_q));

    // R5
    shadow_fill_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mem_q[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/fkr_ctrl.sv
module fkr_ctrl
    import fkr_pkg::*;
#(
    parameter int unsigned              ADDR_W       = FKR_ADDR_W,
    parameter int unsigned              READ_LAT     = FKR_READ_LAT,
    parameter int unsigned              SHADOW_WORDS = FKR_SHADOW_WORDS,
    parameter logic [ADDR_W-1:0]        CTRL_OFF     = FKR_CTRL_OFF,
    parameter logic [ADDR_W-1:0]        DATA_OFF     = FKR_DATA_OFF,
    parameter logic [ADDR_W-1:0]        SHADOW_BASE  = FKR_SHADOW_BASE,
    parameter logic [7:0]               KEY          = FKR_KEY,
    parameter logic [FKR_DATA_W-1:0]    STALE        = FKR_STALE
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [FKR_DATA_W-1:0] req_wdata,
    output logic                  rsp_valid,
    output logic [FKR_DATA_W-1:0] rsp_data
);

    localparam int unsigned      WA_W     = ADDR_W - 2;
    localparam int unsigned      SH_IDX_W = $clog2(SHADOW_WORDS);
    localparam logic [WA_W-1:0]  CTRL_WA  = CTRL_OFF[ADDR_W-1:2];
    localparam logic [WA_W-1:0]  DATA_WA  = DATA_OFF[ADDR_W-1:2];
    localparam logic [WA_W-1:0]  SH_LO    = SHADOW_BASE[ADDR_W-1:2];
    localparam logic [WA_W-1:0]  SH_HI    = SH_LO + WA_W'(SHADOW_WORDS);

    logic [WA_W-1:0]       waddr;
    logic [WA_W-1:0]       sh_off;
    logic                  hit_ctrl;
    logic                  hit_data;
    logic                  hit_sh;
    logic                  rd_req;
    logic                  cmd_wr;
    fkr_ctrl_t             cmd_w;
    fkr_ctrl_t             ctrl_rb;
    logic                  busy;
    logic [FKR_IDX_W-1:0]  idx_q;
    logic [7:0]            key_q;
    logic [FKR_DATA_W-1:0] data_q;
    fkr_done_t             done;
    logic                  sh_wr;
    logic [FKR_DATA_W-1:0] sh_rd;
    logic [FKR_DATA_W-1:0] rd_word;
    logic                  unused_addr;

    assign waddr       = req_addr[ADDR_W-1:2];
    assign unused_addr = ^{req_addr[1:0], sh_off};
    assign sh_off      = waddr - SH_LO;
    assign hit_ctrl    = (waddr == CTRL_WA);
    assign hit_data    = (waddr == DATA_WA);
    assign hit_sh      = (waddr >= SH_LO) && (waddr < SH_HI);
    assign rd_req      = req_valid && !req_write;
    assign cmd_wr      = req_valid && req_write && hit_ctrl;
    assign cmd_w       = fkr_ctrl_t'(req_wdata);

    fkr_seq #(.READ_LAT(READ_LAT), .KEY(KEY)) seq_i (
        .clk      (clk),
        .rst      (rst),
        .cmd_wr   (cmd_wr),
        .cmd_word (cmd_w),
        .busy     (busy),
        .idx_q    (idx_q),
        .key_q    (key_q),
        .data_q   (data_q),
        .done     (done)
    );

    assign sh_wr = done.valid && (32'(done.idx) < SHADOW_WORDS);

    fkr_shadow #(.WORDS(SHADOW_WORDS), .DATA_W(FKR_DATA_W), .STALE(STALE)) shadow_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (sh_wr),
        .wr_idx  (done.idx[SH_IDX_W-1:0]),
        .wr_data (done.word),
        .rd_idx  (sh_off[SH_IDX_W-1:0]),
        .rd_data (sh_rd)
    );

    always_comb begin
        ctrl_rb       = '0;
        ctrl_rb.idx   = idx_q;
        ctrl_rb.key   = key_q;
        ctrl_rb.start = busy;
    end

    always_comb begin
        rd_word = '0;
        if (hit_ctrl) begin
            rd_word = ctrl_rb;
        end else if (hit_data) begin
            rd_word = data_q;
        end else if (hit_sh) begin
            rd_word = sh_rd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= rd_req;
            rsp_data  <= rd_req ? rd_word : '0;
        end
    end

    // R11
    rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rsp_valid);

    // R11
    rsp_cause_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(rd_req));

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !busy && cmd_w.start && (cmd_w.key == KEY)) |=> (busy && (idx_q == $past(cmd_w.idx))));

endmodule

// File: tb/fkr_ctrl_tb.sv
module fkr_ctrl_tb_top;

    localparam time         CLK_PERIOD = 10ns;
    localparam int unsigned LAT        = 16;
    localparam int unsigned NSH        = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr  = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;

    int    checks = 0;
    int    errors = 0;
    bit    finished = 1'b0;
    string phase = "R1";

    always #(CLK_PERIOD / 2) clk = ~clk;

    fkr_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    // Reference model state
    int          m_left;
    int          m_idx;
    int          m_key;
    logic [31:0] m_data;
    logic [31:0] m_sh [NSH];
    logic        exp_valid;
    logic [31:0] exp_data;

    function automatic logic [31:0] ref_fuse(int i);
        logic [31:0] n;
        n = 32'(i + 1);
        return n * 32'h9E3779B1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_left = 0;
            m_idx  = 0;
            m_key  = 0;
            m_data = '0;
            foreach (m_sh[k]) m_sh[k] = 32'hDEADBEEF;
            exp_valid = 1'b0;
            exp_data  = '0;
        end else begin
            exp_valid = req_valid && !req_write;
            exp_data  = '0;
            if (exp_valid) begin
                if (req_addr[11:2] == 10'h010)
                    exp_data = {7'b0, m_idx[8:0], m_key[7:0], 6'b0, (m_left > 0), 1'b0};
                else if (req_addr[11:2] == 10'h018)
                    exp_data = m_data;
                else if (req_addr >= 12'h200 && req_addr < 12'h300)
                    exp_data = m_sh[(int'(req_addr) - 'h200) / 4];
            end
            if (m_left > 0) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    m_data = ref_fuse(m_idx);
                    if (m_idx < NSH) m_sh[m_idx] = m_data;
                end
            end else if (req_valid && req_write && req_addr[11:2] == 10'h010 &&
                         req_wdata[1] && req_wdata[15:8] == 8'hAC) begin
                m_left = LAT;
                m_idx  = int'(req_wdata[24:16]);
                m_key  = int'(req_wdata[15:8]);
            end
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            checks++;
            if (rsp_valid !== exp_valid || (exp_valid && rsp_data !== exp_data)) begin
                errors++;
                $display("FAIL %s: rsp_valid=%0b rsp_data=%08h expected valid=%0b data=%08h",
                         phase, rsp_valid, rsp_data, exp_valid, exp_data);
            end
        end
    end

    task automatic bus_idle();
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr  = '0;
        req_wdata = '0;
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = a;
        req_wdata = d;
    endtask

    task automatic bus_rd(input logic [11:0] a);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b0;
        req_addr  = a;
        req_wdata = '0;
    endtask

    task automatic cmd(input int idx, input logic [7:0] key, input logic go);
        bus_wr(12'h040, {7'b0, 9'(idx), key, 6'b0, go, 1'b0});
    endtask

    task automatic wait_cycles(input int n);
        for (int k = 0; k < n; k++) bus_idle();
    endtask

    task automatic read_shadow(input int i);
        bus_rd(12'(32'h200 + 4 * i));
    endtask

    task automatic fetch(input int idx);
        cmd(idx, 8'hAC, 1'b1);
        wait_cycles(LAT + 2);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        phase = "R1";
        bus_rd(12'h040);
        bus_rd(12'h060);
        for (int i = 0; i < NSH; i++) read_shadow(i);

        // R9: unmapped reads
        phase = "R9";
        bus_rd(12'h000);
        bus_rd(12'h044);
        bus_rd(12'h100);
        bus_rd(12'h300);
        bus_rd(12'hFFC);

        // R2 R3 R10: accepted command, busy polled every cycle
        phase = "R3";
        cmd(5, 8'hAC, 1'b1);
        for (int k = 0; k < LAT + 3; k++) bus_rd(12'h040);

        // R4 R5
        phase = "R4";
        bus_rd(12'h060);
        phase = "R5";
        read_shadow(5);
        read_shadow(4);
        read_shadow(6);

        // R8: clear control after completion
        phase = "R8";
        bus_wr(12'h040, 32'h0);
        bus_rd(12'h060);
        bus_rd(12'h040);

        // R6: wrong key, then start bit clear
        phase = "R6";
        cmd(9, 8'hAB, 1'b1);
        bus_rd(12'h040);
        wait_cycles(LAT + 2);
        bus_rd(12'h060);
        read_shadow(9);
        cmd(9, 8'hAC, 1'b0);
        bus_rd(12'h040);
        wait_cycles(LAT + 2);
        bus_rd(12'h060);
        read_shadow(9);

        // R7: command during busy ignored
        phase = "R7";
        cmd(0, 8'hAC, 1'b1);
        wait_cycles(3);
        cmd(63, 8'hAC, 1'b1);
        bus_rd(12'h040);
        wait_cycles(LAT);
        bus_rd(12'h040);
        bus_rd(12'h060);
        read_shadow(0);
        read_shadow(63);

        // R5: boundary index 63, then out-of-window indices
        phase = "R5";
        fetch(63);
        read_shadow(63);
        bus_rd(12'h060);
        fetch(64);
        bus_rd(12'h060);
        fetch(300);
        bus_rd(12'h060);
        fetch(511);
        bus_rd(12'h040);
        bus_rd(12'h060);
        for (int i = 0; i < NSH; i++) read_shadow(i);

        // R9: writes to data register, shadow and unmapped space
        phase = "R9";
        bus_wr(12'h060, 32'h12345678);
        bus_wr(12'h200, 32'h11111111);
        bus_wr(12'h2FC, 32'h22222222);
        bus_wr(12'h208, 32'h33333333);
        bus_wr(12'h100, 32'h44444444);
        bus_rd(12'h060);
        read_shadow(0);
        read_shadow(63);
        read_shadow(2);
        bus_rd(12'h100);

        // R11: back-to-back reads mixed with writes
        phase = "R11";
        bus_rd(12'h040);
        bus_wr(12'h300, 32'h1);
        bus_rd(12'h060);
        bus_rd(12'h060);
        wait_cycles(2);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule